// File: doc/BRIEF.md
# Staggered Channel Enable Sequencer

This block turns a vector of per-channel on/off bits and one global blanking input into a vector of drive enables. The current sinks downstream use these enables. When many outputs switch at the same moment they draw a large inrush current. To avoid that, each channel's enable is held back by a fixed step multiplied by its channel index. Channel 0 switches first, and channel n switches n steps later. The stagger applies to both turn-on and turn-off.

The block first combines each on/off bit with the inverted blank input. It then passes the result through a per-channel shift-register delay line. An edge is gated only when it enters its line, so a change on blank after that point cannot stop or cut short an edge that is already in flight. As a result, every lit channel stays on for exactly as many cycles as blank was low, only shifted in time. The step is a parameter counted in system clock cycles.

Top module: `stagger_seq`

## Requirements
- R1: While the reset input is low, every drive bit is 0, no matter what the on/off and blank inputs are. Reset clears every delay stage. After reset is released, the first input sample is taken at the third rising clock edge.
- R2: Channel 0 has no added stagger. After a rising edge, drive bit 0 equals (on/off bit 0 AND NOT blank) as sampled at that same edge.
- R3: A turn-on on channel n appears n×STEP_CYC cycles after the same turn-on appears on channel 0.
- R4: A turn-off follows the same spacing of n×STEP_CYC cycles per channel index as a turn-on.
- R5: Once blank has been high for long enough to flush every delay line, all drive bits are 0 whatever the on/off vector holds.
- R6: Once blank has been low and the on/off vector has stayed unchanged for long enough to flush every delay line, the drive vector equals the on/off vector (bit n drives channel n).
- R7: An edge that has entered a channel's delay line comes out at its scheduled cycle even if blank changes afterwards. With all on/off bits set, a low pulse on blank of L cycles lights each channel for exactly L cycles.
- R8: A change of the on/off vector while blank is low travels through the same staggered delay as a blank transition.
- R9: A one-cycle request on the last channel reaches its output as a one-cycle drive pulse, after the full stagger. The pulse is neither lost nor stretched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| onoff | input | NUM_CH | Latched per-channel on/off bits |
| blank | input | 1 | Global blanking; high forces the requests off |
| drive | output | NUM_CH | Staggered per-channel drive enables |

## Verification
The bench builds the block with 16 channels and a step of 2 cycles. This makes the last channel lag channel 0 by 30 cycles, and neighbouring channels differ by more than a single register. An off-by-one in the tap depth, or a step that is ignored, therefore shows up directly at the outputs. With a 30-cycle spread, a 5-cycle blank pulse has fully left the early channels before it has even reached the late ones. This exposes any gating that is applied at the output rather than at the entry to the delay line. A one-cycle request on the last channel checks that the deepest tap keeps the width of a pulse.

// File: rtl/stagger_pkg.sv
package stagger_pkg;

  // Number of register stages between the request and the drive of a channel.
  // Channel 0 keeps a single register; each later channel adds STEP stages.
  function automatic int tap_depth(input int ch, input int step);
    return ch * step + 1;
  endfunction

  // Largest lag, in cycles, between channel 0 and the last channel.
  function automatic int max_lag(input int num_ch, input int step);
    return (num_ch - 1) * step;
  endfunction

endpackage

// File: rtl/stg_rst_sync.sv
module stg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic hold_q;
  logic meta_d;
  logic hold_d;

  always_comb begin
    meta_d = 1'b1;
    hold_d = meta_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      hold_q <= hold_d;
    end
  end

  assign srst_n = hold_q;
endmodule

// File: rtl/stg_req_gate.sv
module stg_req_gate #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] onoff,
  input  logic             blank,
  output logic [WIDTH-1:0] req
);
  // Gating happens only here, at the entry of the delay lines.
  always_comb begin
    req = onoff & ~{WIDTH{blank}};
  end
endmodule

// File: rtl/stg_tap_line.sv
module stg_tap_line #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  if (DEPTH == 1) begin : g_single
    logic bit_d;
    logic bit_q;

    always_comb begin
      bit_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else begin
        bit_q <= bit_d;
      end
    end

    assign dout = bit_q;
  end else begin : g_chain
    logic [DEPTH-1:0] sh_d;
    logic [DEPTH-1:0] sh_q;

    always_comb begin
      sh_d = {sh_q[DEPTH-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '0;
      end else begin
        sh_q <= sh_d;
      end
    end

    assign dout = sh_q[DEPTH-1];
  end
endmodule

// File: rtl/stagger_seq.sv
module stagger_seq
  import stagger_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int STEP_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] onoff,
  input  logic              blank,
  output logic [NUM_CH-1:0] drive
);
  localparam int LAG = max_lag(NUM_CH, STEP_CYC);

  logic              rst_int_n;
  logic [NUM_CH-1:0] req;

  stg_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  stg_req_gate #(.WIDTH(NUM_CH)) u_gate (
    .onoff (onoff),
    .blank (blank),
    .req   (req)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    stg_tap_line #(.DEPTH(tap_depth(ch, STEP_CYC))) u_line (
      .clk   (clk),
      .rst_n (rst_int_n),
      .din   (req[ch]),
      .dout  (drive[ch])
    );
  end

  if (LAG < 0) begin : g_bad_param
    initial $error("stagger_seq: NUM_CH and STEP_CYC must be positive");
  end
endmodule

// File: rtl/stagger_seq_chk.sv
module stagger_seq_chk #(
  parameter int NUM_CH   = 16,
  parameter int STEP_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] onoff,
  input logic              blank,
  input logic [NUM_CH-1:0] drive
);
  localparam int LAG  = (NUM_CH - 1) * STEP_CYC;
  localparam int SAT  = LAG + 8;
  localparam int CW   = $clog2(SAT + 1) + 1;

  logic [CW-1:0]     arm_cnt;
  logic [CW-1:0]     hi_cnt;
  logic [CW-1:0]     still_cnt;
  logic [NUM_CH-1:0] prev_onoff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_cnt    <= '0;
      hi_cnt     <= '0;
      still_cnt  <= '0;
      prev_onoff <= '0;
    end else begin
      prev_onoff <= onoff;
      if (arm_cnt < CW'(SAT)) arm_cnt <= arm_cnt + 1'b1;
      if (blank) begin
        if (hi_cnt < CW'(SAT)) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
      end
      if (!blank && onoff == prev_onoff) begin
        if (still_cnt < CW'(SAT)) still_cnt <= still_cnt + 1'b1;
      end else begin
        still_cnt <= '0;
      end
    end
  end

  // R1: reset forces every enable off
  p_rst_clear_r1: assert property (@(posedge clk) !rst_n |-> drive == '0);

  // R2: channel 0 carries only one register
  p_ch0_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_cnt >= CW'(3)) |-> drive[0] == $past(onoff[0] & ~blank));

  // R5: blank held long enough empties every line
  p_blank_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt >= CW'(LAG + 1)) |-> drive == '0);

  // R6: steady unblanked pattern reaches every channel
  p_steady_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (still_cnt >= CW'(LAG + 2) && arm_cnt >= CW'(LAG + 4)) |-> drive == prev_onoff);
endmodule

bind stagger_seq stagger_seq_chk #(.NUM_CH(NUM_CH), .STEP_CYC(STEP_CYC)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .onoff (onoff),
  .blank (blank),
  .drive (drive)
);

// File: tb/stagger_seq_test.sv
`timescale 1ns/1ps
module stagger_seq_test;
  localparam int NCH  = 16;
  localparam int STEP = 2;
  localparam int LAST = (NCH - 1) * STEP;
  localparam int HMAX = 4096;

  typedef struct packed {
    logic [15:0] oo;
    logic        bl;
    logic [7:0]  reps;
    logic [3:0]  tag;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t TBL [NVEC] = '{
    '{16'hFFFF, 1'b0, 8'd40, 4'd3},
    '{16'hFFFF, 1'b1, 8'd40, 4'd4},
    '{16'hA5C3, 1'b0, 8'd40, 4'd6},
    '{16'h5A3C, 1'b0, 8'd40, 4'd8},
    '{16'hFFFF, 1'b1, 8'd40, 4'd5},
    '{16'h0001, 1'b0, 8'd1,  4'd2},
    '{16'h0000, 1'b0, 8'd5,  4'd2},
    '{16'h8000, 1'b0, 8'd1,  4'd9},
    '{16'h0000, 1'b0, 8'd40, 4'd9}
  };

  logic           clk;
  logic           rst_n;
  logic           blank;
  logic [NCH-1:0] onoff;
  logic [NCH-1:0] drive;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int valid_from = 0;
  bit in_rst = 1'b1;
  bit done   = 1'b0;
  logic [NCH-1:0] hist [HMAX];
  int lit [NCH];

  stagger_seq #(.NUM_CH(NCH), .STEP_CYC(STEP)) uut (
    .clk   (clk),
    .rst_n (rst_n),
    .onoff (onoff),
    .blank (blank),
    .drive (drive)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Expected drive after edge e: channel n shows the request taken n*STEP edges earlier.
  function automatic logic [NCH-1:0] model(input int e);
    logic [NCH-1:0] v;
    v = '0;
    for (int n = 0; n < NCH; n++) begin
      int src;
      src = e - n * STEP;
      if (src >= valid_from) v[n] = hist[src][n];
    end
    return v;
  endfunction

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic chk_vec(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // Called at a falling edge: apply inputs, pass one rising edge, check at the next falling edge.
  task automatic tick(input logic [NCH-1:0] oo, input logic bl, input string tag);
    onoff = oo;
    blank = bl;
    if (cyc < HMAX) hist[cyc] = oo & ~{NCH{bl}};
    @(posedge clk);
    @(negedge clk);
    chk_vec(tag, drive, in_rst ? '0 : model(cyc));
    for (int n = 0; n < NCH; n++) if (drive[n]) lit[n]++;
    cyc++;
  endtask

  task automatic clear_lit();
    for (int n = 0; n < NCH; n++) lit[n] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    blank = 1'b0;
    onoff = '1;
    @(negedge clk);
    // R1: inputs request light during reset, outputs must stay off
    for (int i = 0; i < 4; i++) tick('1, 1'b0, "R1");
    rst_n      = 1'b1;
    in_rst     = 1'b0;
    valid_from = cyc + 2;
    for (int i = 0; i < 5; i++) tick('1, 1'b1, "R1");

    // Vector table: R2, R3, R4, R5, R6, R8, R9 against the stagger model
    for (int v = 0; v < NVEC; v++) begin
      for (int r = 0; r < int'(TBL[v].reps); r++)
        tick(TBL[v].oo, TBL[v].bl, tag_name(int'(TBL[v].tag)));
    end

    // R9: a single-cycle request on the deepest channel keeps its width
    clear_lit();
    tick(16'h8000, 1'b0, "R9");
    for (int i = 0; i < LAST + 4; i++) tick('0, 1'b0, "R9");
    chk_int("R9", lit[NCH-1], 1);

    // R7: blank low for 5 cycles; late channels turn on after blank is high again
    for (int i = 0; i < LAST + 2; i++) tick('1, 1'b1, "R7");
    clear_lit();
    for (int i = 0; i < 5; i++) tick('1, 1'b0, "R7");
    for (int i = 0; i < LAST + 4; i++) tick('1, 1'b1, "R7");
    for (int n = 0; n < NCH; n++) chk_int("R7", lit[n], 5);

    // R3/R4: single channel 5 on then off, measured against channel 0 timing via model
    for (int i = 0; i < LAST + 2; i++) tick(16'h0021, 1'b0, "R3");
    for (int i = 0; i < LAST + 2; i++) tick(16'h0000, 1'b0, "R4");

    // R1: reset in the middle of activity clears the outputs at once
    for (int i = 0; i < LAST + 2; i++) tick('1, 1'b0, "R6");
    rst_n  = 1'b0;
    in_rst = 1'b1;
    #1;
    chk_vec("R1", drive, '0);
    for (int i = 0; i < 3; i++) tick('1, 1'b0, "R1");
    rst_n      = 1'b1;
    in_rst     = 1'b0;
    valid_from = cyc + 2;
    for (int i = 0; i < 3; i++) tick('1, 1'b1, "R1");
    for (int i = 0; i < LAST + 4; i++) tick(16'h3C3C, 1'b0, "R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule